// File: doc/BRIEF.md
# Eight-Pin Direction-Controlled GPIO Register Bank

This block is the register side of a small general-purpose I/O port. A serial front end, which is not part of this block, decodes bus traffic into write strobes and read requests that carry a 2-bit register pointer. The block holds three writable registers: the drive value, the polarity mask and the direction mask. Pointer 0 selects a read-only view of the pins.

The block drives an output enable and an output value for each pin toward tri-state pads. It samples the pin levels through a two-flop synchronizer. A read request captures the selected register into a holding register, which the front end then shifts out. A pin read returns the synchronized pin levels XORed with the polarity mask. A drive-register read returns the stored value, not the level on the pin.

Top module: `gpio_regbank`

## Requirements
- R1: A read with pointer 0 returns the synchronized pin levels XORed bit by bit with the polarity register (pointer 2). A polarity bit of 1 inverts its pin in the result.
- R2: A write with pointer 0 changes no register. A later read of pointers 1, 2 and 3 returns the values those registers held before that write.
- R3: A read with pointer 0 shows the level of every pin, whether the pin is currently set as an input or as an output.
- R4: A read with pointer 1 returns the stored drive value, even when the pin levels differ from it.
- R5: A direction bit of 1 makes the pin an input, and `pin_oe` for that bit is 0. A direction bit of 0 makes it an output, and `pin_oe` is 1. `pin_oe` follows a write with pointer 3 one clock after the write edge.
- R6: For an output pin, `pin_out` carries the drive register bit. For an input pin, `pin_out` is 0 whatever the drive bit. `pin_out` updates one clock after the write edge.
- R7: After reset the drive register is 0xFF, the polarity register is 0x00 and the direction register is 0xFF, so every pin is an input. Also after reset, `pin_oe` = 0x00, `pin_out` = 0x00 and `rd_data` = 0x00.
- R8: A pin level takes two clock edges to pass the synchronizer. A read captured at edge k returns the level that was on `pin_in` just before edge k-2.
- R9: `rd_data` loads only on a clock edge where `rd_req` is 1. On every other edge it holds its value.
- R10: The pointer encoding is 0 for the pins, 1 for drive, 2 for polarity and 3 for direction. A write lands in the register its pointer selects, on the edge where `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register pointer for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_req | input | 1 | Read request; captures the selected register |
| rd_data | output | 8 | Captured read data |
| pin_in | input | 8 | Pin levels from the pads (asynchronous) |
| pin_oe | output | 8 | Per-pin driver enable |
| pin_out | output | 8 | Per-pin drive value |

## Verification
The bench changes the pins in the cycles right before a read, so a synchronizer with one stage too few or too many returns the wrong cycle's level. It sets polarity bits and reads the pins while some are outputs. A read path that skips the XOR, or that masks output pins, then returns a wrong byte. It writes pointer 0 and checks the other three registers afterward, which catches a decoder that lets that write alias onto another register. It also reads the drive register with pin levels that differ from it, which exposes a design that returns the pin instead of the stored value. It flips the direction register both ways and checks that an input pin never carries the drive bit on `pin_out`.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
    typedef enum logic [1:0] {
        SEL_PINS   = 2'd0,
        SEL_DRIVE  = 2'd1,
        SEL_INVERT = 2'd2,
        SEL_DIR    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_regbank_pkg::*;
#(
    parameter int           W       = 8,
    parameter logic [W-1:0] DRV_RST = '1,
    parameter logic [W-1:0] INV_RST = '0,
    parameter logic [W-1:0] DIR_RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] drive_q,
    output logic [W-1:0] invert_q,
    output logic [W-1:0] dir_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q  <= DRV_RST;
            invert_q <= INV_RST;
            dir_q    <= DIR_RST;
        end else if (wr_en) begin
            unique case (sel)
                SEL_PINS:   ;
                SEL_DRIVE:  drive_q  <= wr_data;
                SEL_INVERT: invert_q <= wr_data;
                SEL_DIR:    dir_q    <= wr_data;
                default:    ;
            endcase
        end
    end

    AST_PIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_PINS) |=> ($stable(drive_q) && $stable(invert_q) && $stable(dir_q))); // R2
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] drive_q,
    input  logic [W-1:0] dir_q,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pin_oe[b]  <= 1'b0;
                    pin_out[b] <= 1'b0;
                end else begin
                    pin_oe[b]  <= ~dir_q[b];
                    pin_out[b] <= drive_q[b] & ~dir_q[b];
                end
            end
        end
    endgenerate

    AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0)); // R6
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
    import gpio_regbank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_req,
    input  reg_sel_e     sel,
    input  logic [W-1:0] pins_sync,
    input  logic [W-1:0] drive_q,
    input  logic [W-1:0] invert_q,
    input  logic [W-1:0] dir_q,
    output logic [W-1:0] rd_data
);
    logic [W-1:0] sel_val;

    always_comb begin
        unique case (sel)
            SEL_PINS:   sel_val = pins_sync ^ invert_q;
            SEL_DRIVE:  sel_val = drive_q;
            SEL_INVERT: sel_val = invert_q;
            SEL_DIR:    sel_val = dir_q;
            default:    sel_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= sel_val;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data)); // R9
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_regbank_pkg::*;
#(
    parameter int           W           = 8,
    parameter int           SYNC_STAGES = 2,
    parameter logic [W-1:0] DRV_RST     = '1,
    parameter logic [W-1:0] INV_RST     = '0,
    parameter logic [W-1:0] DIR_RST     = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   reg_sel,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_req,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);
    reg_sel_e     sel;
    logic [W-1:0] pins_sync;
    logic [W-1:0] drive_q;
    logic [W-1:0] invert_q;
    logic [W-1:0] dir_q;

    assign sel = reg_sel_e'(reg_sel);

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    gpio_ctrl_regs #(.W(W), .DRV_RST(DRV_RST), .INV_RST(INV_RST), .DIR_RST(DIR_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel      (sel),
        .wr_data  (wr_data),
        .drive_q  (drive_q),
        .invert_q (invert_q),
        .dir_q    (dir_q)
    );

    gpio_pad_drive #(.W(W)) u_pad (
        .clk     (clk),
        .rst_n   (rst_n),
        .drive_q (drive_q),
        .dir_q   (dir_q),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    gpio_read_port #(.W(W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .sel       (sel),
        .pins_sync (pins_sync),
        .drive_q   (drive_q),
        .invert_q  (invert_q),
        .dir_q     (dir_q),
        .rd_data   (rd_data)
    );

    AST_DIR_WRITE_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd3) |=> ##1 (pin_oe == ~$past(wr_data, 2))); // R5

    AST_DRIVE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && reg_sel == 2'd1) |=> (rd_data == $past(drive_q))); // R4

    AST_DRIVE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd1) |=> (drive_q == $past(wr_data))); // R10
endmodule

// File: tb/sim_gpio_regbank.sv
module sim_gpio_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_req = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;

    always #5 clk = ~clk;

    gpio_regbank u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R7";

    // behavioural reference
    logic [7:0] m_drv, m_inv, m_dir, m_rd, m_oe, m_out;
    logic [7:0] pin_hist [$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_drv = 8'hFF; m_inv = 8'h00; m_dir = 8'hFF;
            m_rd = 8'h00; m_oe = 8'h00; m_out = 8'h00;
            pin_hist = {8'h00, 8'h00};
        end else begin
            logic [7:0] seen;
            seen = pin_hist[0];
            pin_hist.pop_front();
            pin_hist.push_back(pin_in);
            if (rd_req) begin
                case (reg_sel)
                    2'd0: m_rd = seen ^ m_inv;
                    2'd1: m_rd = m_drv;
                    2'd2: m_rd = m_inv;
                    default: m_rd = m_dir;
                endcase
            end
            for (int b = 0; b < 8; b++) begin
                m_oe[b]  = (m_dir[b] == 1'b0);
                m_out[b] = (m_dir[b] == 1'b0) ? m_drv[b] : 1'b0;
            end
            if (wr_en) begin
                if (reg_sel == 2'd1) m_drv = wr_data;
                if (reg_sel == 2'd2) m_inv = wr_data;
                if (reg_sel == 2'd3) m_dir = wr_data;
            end
        end
    end

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%02h expected=%02h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        chk("rd_data", rd_data, m_rd);
        chk("pin_oe", pin_oe, m_oe);
        chk("pin_out", pin_out, m_out);
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] p, logic [7:0] d);
        @(negedge clk);
        reg_sel = p; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] p);
        @(negedge clk);
        reg_sel = p; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        cur_req = "R7"; idle(3); rd(2'd1); rd(2'd2); rd(2'd3); idle(1);
        cur_req = "R1"; pin_in = 8'hA5; idle(3); rd(2'd0);
        wr(2'd2, 8'h0F); rd(2'd0); idle(1);
        cur_req = "R8";
        @(negedge clk); pin_in = 8'h3C; reg_sel = 2'd0; rd_req = 1'b1;
        idle(4); rd_req = 1'b0; idle(1);
        cur_req = "R2"; wr(2'd0, 8'h55); rd(2'd1); rd(2'd2); rd(2'd3);
        cur_req = "R5"; wr(2'd3, 8'hF0); idle(2);
        cur_req = "R6"; wr(2'd1, 8'h96); idle(2);
        cur_req = "R4"; pin_in = 8'h00; idle(3); rd(2'd1);
        cur_req = "R3"; pin_in = 8'h5A; idle(3); rd(2'd0);
        cur_req = "R9"; pin_in = 8'hFF; idle(4); pin_in = 8'h11; idle(3);
        cur_req = "R10"; wr(2'd2, 8'hC3); rd(2'd2); wr(2'd3, 8'h3C); rd(2'd3); rd(2'd0);
        cur_req = "R6"; wr(2'd3, 8'h00); idle(2); wr(2'd1, 8'h69); idle(2);
        wr(2'd3, 8'hFF); idle(2);
        cur_req = "R5"; wr(2'd3, 8'hAA); idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule